// File: doc/BRIEF.md
# Serial Link Bring-Up Monitor with Stuck-Recovery Repair

After the link state machine of a serial interconnect controller has been allowed to train, this block decides whether the link came up. Each attempt it samples two status words from the link layer. When the link looks down, it reads a receiver status register in the PHY through a simple request/acknowledge register port. If the second-generation speed change has stalled in the receiver-lock recovery state with no valid receive data, the block repairs it. It sets two receiver override bits in a PHY override register by read-modify-write, holds them for a programmed time, and then clears them the same way.

Attempts are spaced by a programmable gap and are bounded in number. A start pulse opens a new monitoring run with the attempt count at zero. The run ends either with `link_ok_o` or with `link_fail_o`. In the failure case the status words from the final attempt are kept on the outputs for diagnosis. All delays are counted in clock cycles, so a short configuration can be used for simulation.

Top module: `link_train_mon`

## Requirements
- R1: After reset, `busy_o`, `link_ok_o`, `link_fail_o` and `phy_req_o` are all low.
- R2: An attempt treats the link as established only when `link_word_i` bit 4 is 1 and bit 29 is 0. The block then enters the success state (`link_ok_o` high, `busy_o` low) without any PHY access in that attempt. All other combinations of these two bits count as down.
- R3: Every attempt that finds the link down first reads PHY register `RXSTAT_ADDR` (default 0x100D). Recovery follows only when bit 0 of that read is 0 and `state_word_i[5:0]` equals 0x0D. Bits 31:6 of `state_word_i` and bits 15:1 of the read value have no effect.
- R4: Recovery does four accesses in order. It reads `OVRD_ADDR` (default 0x1005) and writes back the value with bits 5 and 3 set. It then waits at least `HOLD_CYC` cycles, reads `OVRD_ADDR` again, and writes back the value with bits 5 and 3 cleared. All other bits keep the value just read.
- R5: `phy_req_o` stays high with stable `phy_wr_o`, `phy_addr_o` and `phy_wdata_o` until the cycle in which `phy_ack_i` is high. It is low in the next cycle, and only one access is outstanding at a time.
- R6: If `phy_err_i` is high together with `phy_ack_i`, the attempt ends at once and skips its remaining accesses. An errored write does not count as a write. The attempt still counts as a down attempt, and polling continues.
- R7: The end of one attempt and the first request of the next are at least `GAP_CYC` cycles apart.
- R8: After `MAX_ATTEMPTS` down attempts, `link_fail_o` goes high and `busy_o` goes low. `last_state_word_o` and `last_link_word_o` then hold the status words sampled at the start of the final attempt.
- R9: `start_i` in the idle, success or failure state clears the result, resets the attempt count to zero and begins a new run. `start_i` while `busy_o` is high has no effect.
- R10: `link_ok_o` and `link_fail_o` are never high together, and `busy_o` is low whenever either of them is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a monitoring run |
| state_word_i | input | DBG_W | Link-layer status word holding the link state in bits 5:0 |
| link_word_i | input | DBG_W | Link-layer status word: bit 4 link up, bit 29 in training |
| phy_req_o | output | 1 | PHY register access request |
| phy_wr_o | output | 1 | 1 = write, 0 = read |
| phy_addr_o | output | ADDR_W | PHY register address |
| phy_wdata_o | output | DATA_W | PHY write data |
| phy_ack_i | input | 1 | One-cycle completion of the current access |
| phy_err_i | input | 1 | Access failed, valid with `phy_ack_i` |
| phy_rdata_i | input | DATA_W | Read data, valid with `phy_ack_i` |
| busy_o | output | 1 | A run is in progress |
| link_ok_o | output | 1 | Run ended with the link established |
| link_fail_o | output | 1 | Run ended with all attempts used up |
| last_state_word_o | output | DBG_W | `state_word_i` captured at the start of the last attempt |
| last_link_word_o | output | DBG_W | `link_word_i` captured at the start of the last attempt |

## Verification
The repair decision is swept over all 64 values of the six-bit link state, each with the receive-valid bit both set and clear. The ignored upper bits and the link-word patterns change on every step, so the sweep separates the single stuck combination, which must produce exactly two override writes per attempt, from the 127 combinations that must produce none. A four-case table over the up and in-training bits separates the one established combination from its three look-alikes. Further patterns cover an error at chosen positions in the recovery sequence, a link that comes up after a given number of attempts, a start pulse during a run, and a PHY with zero to two cycles of response latency. These show which accesses are skipped, how attempts are counted, and that the timing rules hold whatever the PHY latency.

// File: rtl/ltm_pkg.sv
package ltm_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_CHECK,
    ST_RD_VALID,
    ST_RD_SET,
    ST_WR_SET,
    ST_HOLD,
    ST_RD_CLR,
    ST_WR_CLR,
    ST_END,
    ST_GAP,
    ST_OK,
    ST_FAIL
  } ltm_state_e;

  // field positions fixed by the link layer and the PHY
  localparam int          UP_BIT      = 4;
  localparam int          TRAIN_BIT   = 29;
  localparam int          STATE_W     = 6;
  localparam logic [5:0]  RLOCK_STATE = 6'h0D;
  localparam int          RXVALID_BIT = 0;
  localparam int          OVR_DATA_EN = 5;
  localparam int          OVR_PLL_EN  = 3;

endpackage

// File: rtl/ltm_status_decode.sv
module ltm_status_decode
  import ltm_pkg::*;
(
  input  logic               up_bit_i,
  input  logic               train_bit_i,
  input  logic [STATE_W-1:0] state_i,
  input  logic               rx_valid_i,
  output logic               link_up_o,
  output logic               stuck_o
);

  assign link_up_o = up_bit_i & ~train_bit_i;
  assign stuck_o   = (state_i == RLOCK_STATE) & ~rx_valid_i;

endmodule

// File: rtl/ltm_phy_port.sv
module ltm_phy_port #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              launch_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              phy_req_o,
  output logic              phy_wr_o,
  output logic [ADDR_W-1:0] phy_addr_o,
  output logic [DATA_W-1:0] phy_wdata_o,
  input  logic              phy_ack_i,
  input  logic              phy_err_i,
  input  logic [DATA_W-1:0] phy_rdata_i
);

  logic              req_q, wr_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q   <= 1'b0;
      wr_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (req_q && phy_ack_i) begin
      req_q <= 1'b0;
    end else if (launch_i && !req_q) begin
      req_q   <= 1'b1;
      wr_q    <= wr_i;
      addr_q  <= addr_i;
      wdata_q <= wdata_i;
    end
  end

  assign busy_o      = req_q;
  assign done_o      = req_q & phy_ack_i;
  assign err_o       = req_q & phy_ack_i & phy_err_i;
  assign rdata_o     = phy_rdata_i;
  assign phy_req_o   = req_q;
  assign phy_wr_o    = wr_q;
  assign phy_addr_o  = addr_q;
  assign phy_wdata_o = wdata_q;

  // R5: request held with stable fields until acknowledged
  a_r5_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phy_req_o && !phy_ack_i |=> phy_req_o && $stable(phy_addr_o) && $stable(phy_wr_o)
                                && $stable(phy_wdata_o));

  // R5: request drops right after acknowledge
  a_r5_req_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phy_req_o && phy_ack_i |=> !phy_req_o);

endmodule

// File: rtl/ltm_timer.sv
module ltm_timer #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] value_i,
  output logic         expired_o
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= value_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);

endmodule

// File: rtl/ltm_attempt_ctr.sv
module ltm_attempt_ctr #(
  parameter int MAX = 2000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  output logic last_o
);

  localparam int CNT_W = $clog2(MAX + 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (inc_i)  cnt_q <= cnt_q + 1'b1;
  end

  assign last_o = (cnt_q == CNT_W'(MAX - 1));

  // R8: the count never passes the attempt limit
  a_r8_no_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_i |-> cnt_q < CNT_W'(MAX));

endmodule

// File: rtl/link_train_mon.sv
module link_train_mon
  import ltm_pkg::*;
#(
  parameter int              ADDR_W       = 16,
  parameter int              DATA_W       = 16,
  parameter int              DBG_W        = 32,
  parameter int              MAX_ATTEMPTS = 2000,
  parameter int              HOLD_CYC     = 300000,
  parameter int              GAP_CYC      = 1000,
  parameter logic [ADDR_W-1:0] RXSTAT_ADDR = 16'h100D,
  parameter logic [ADDR_W-1:0] OVRD_ADDR   = 16'h1005
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [DBG_W-1:0]  state_word_i,
  input  logic [DBG_W-1:0]  link_word_i,
  output logic              phy_req_o,
  output logic              phy_wr_o,
  output logic [ADDR_W-1:0] phy_addr_o,
  output logic [DATA_W-1:0] phy_wdata_o,
  input  logic              phy_ack_i,
  input  logic              phy_err_i,
  input  logic [DATA_W-1:0] phy_rdata_i,
  output logic              busy_o,
  output logic              link_ok_o,
  output logic              link_fail_o,
  output logic [DBG_W-1:0]  last_state_word_o,
  output logic [DBG_W-1:0]  last_link_word_o
);

  localparam int TMR_MAX = (HOLD_CYC > GAP_CYC) ? HOLD_CYC : GAP_CYC;
  localparam int TMR_W   = $clog2(TMR_MAX + 1);
  localparam logic [DATA_W-1:0] OVR_MASK = (DATA_W'(1) << OVR_DATA_EN) |
                                           (DATA_W'(1) << OVR_PLL_EN);

  ltm_state_e        state_q, state_d;
  logic [DATA_W-1:0] rmw_q, rmw_d;
  logic [DBG_W-1:0]  last0_q, last1_q;
  logic              capture;

  logic              is_op, op_wr, launch;
  logic [ADDR_W-1:0] op_addr;
  logic              port_busy, done, acc_err;
  logic [DATA_W-1:0] rdata;

  logic              link_up, stuck;
  logic              cnt_clr, cnt_inc, cnt_last;
  logic              tmr_load, tmr_exp;
  logic [TMR_W-1:0]  tmr_val;

  // access selection per state
  always_comb begin
    is_op   = 1'b0;
    op_wr   = 1'b0;
    op_addr = OVRD_ADDR;
    unique case (state_q)
      ST_RD_VALID: begin is_op = 1'b1; op_addr = RXSTAT_ADDR; end
      ST_RD_SET,
      ST_RD_CLR:   is_op = 1'b1;
      ST_WR_SET,
      ST_WR_CLR:   begin is_op = 1'b1; op_wr = 1'b1; end
      default: ;
    endcase
  end

  assign launch = is_op & ~port_busy;

  ltm_phy_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_port (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .launch_i    (launch),
    .wr_i        (op_wr),
    .addr_i      (op_addr),
    .wdata_i     (rmw_q),
    .busy_o      (port_busy),
    .done_o      (done),
    .err_o       (acc_err),
    .rdata_o     (rdata),
    .phy_req_o   (phy_req_o),
    .phy_wr_o    (phy_wr_o),
    .phy_addr_o  (phy_addr_o),
    .phy_wdata_o (phy_wdata_o),
    .phy_ack_i   (phy_ack_i),
    .phy_err_i   (phy_err_i),
    .phy_rdata_i (phy_rdata_i)
  );

  ltm_status_decode u_dec (
    .up_bit_i    (link_word_i[UP_BIT]),
    .train_bit_i (link_word_i[TRAIN_BIT]),
    .state_i     (state_word_i[STATE_W-1:0]),
    .rx_valid_i  (rdata[RXVALID_BIT]),
    .link_up_o   (link_up),
    .stuck_o     (stuck)
  );

  ltm_attempt_ctr #(.MAX(MAX_ATTEMPTS)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (cnt_clr),
    .inc_i  (cnt_inc),
    .last_o (cnt_last)
  );

  ltm_timer #(.W(TMR_W)) u_tmr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (tmr_load),
    .value_i   (tmr_val),
    .expired_o (tmr_exp)
  );

  always_comb begin
    state_d  = state_q;
    rmw_d    = rmw_q;
    cnt_clr  = 1'b0;
    cnt_inc  = 1'b0;
    tmr_load = 1'b0;
    tmr_val  = TMR_W'(GAP_CYC);
    capture  = 1'b0;
    unique case (state_q)
      ST_IDLE, ST_OK, ST_FAIL: begin
        if (start_i) begin
          state_d = ST_CHECK;
          cnt_clr = 1'b1;
        end
      end
      ST_CHECK: begin
        capture = 1'b1;
        state_d = link_up ? ST_OK : ST_RD_VALID;
      end
      ST_RD_VALID: begin
        if (done) state_d = (acc_err || !stuck) ? ST_END : ST_RD_SET;
      end
      ST_RD_SET: begin
        if (done) begin
          state_d = acc_err ? ST_END : ST_WR_SET;
          rmw_d   = rdata | OVR_MASK;
        end
      end
      ST_WR_SET: begin
        if (done) begin
          if (acc_err) begin
            state_d = ST_END;
          end else begin
            state_d  = ST_HOLD;
            tmr_load = 1'b1;
            tmr_val  = TMR_W'(HOLD_CYC);
          end
        end
      end
      ST_HOLD: begin
        if (tmr_exp) state_d = ST_RD_CLR;
      end
      ST_RD_CLR: begin
        if (done) begin
          state_d = acc_err ? ST_END : ST_WR_CLR;
          rmw_d   = rdata & ~OVR_MASK;
        end
      end
      ST_WR_CLR: begin
        if (done) state_d = ST_END;
      end
      ST_END: begin
        cnt_inc = 1'b1;
        if (cnt_last) begin
          state_d = ST_FAIL;
        end else begin
          state_d  = ST_GAP;
          tmr_load = 1'b1;
        end
      end
      ST_GAP: begin
        if (tmr_exp) state_d = ST_CHECK;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      rmw_q   <= '0;
      last0_q <= '0;
      last1_q <= '0;
    end else begin
      state_q <= state_d;
      rmw_q   <= rmw_d;
      if (capture) begin
        last0_q <= state_word_i;
        last1_q <= link_word_i;
      end
    end
  end

  assign link_ok_o         = (state_q == ST_OK);
  assign link_fail_o       = (state_q == ST_FAIL);
  assign busy_o            = !(state_q inside {ST_IDLE, ST_OK, ST_FAIL});
  assign last_state_word_o = last0_q;
  assign last_link_word_o  = last1_q;

  // R10: exclusive results, never busy with a result
  a_r10_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(link_ok_o && link_fail_o));
  a_r10_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (link_ok_o || link_fail_o) |-> !busy_o);

  // R2: no PHY traffic while reporting success
  a_r2_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    link_ok_o |-> !phy_req_o);

  // R8: failure result and diagnostics hold until the next start
  a_r8_fail_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    link_fail_o && !start_i |=> link_fail_o && $stable(last_state_word_o)
                                && $stable(last_link_word_o));

  // R9: a start pulse while busy keeps the run going
  a_r9_busy_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && start_i && !link_ok_o |=> !(state_q == ST_CHECK && $past(state_q) != ST_GAP
                                          && $past(state_q) != ST_IDLE
                                          && $past(state_q) != ST_OK
                                          && $past(state_q) != ST_FAIL));

endmodule

// File: tb/sim_link_train_mon.sv
`timescale 1ns/1ps
module sim_link_train_mon;

  localparam int MAXA = 4;
  localparam int HOLD = 12;
  localparam int GAP  = 6;
  localparam logic [15:0] RXS  = 16'h100D;
  localparam logic [15:0] OVR  = 16'h1005;
  localparam logic [15:0] MASK = 16'h0028;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        start = 1'b0;
  logic [31:0] w0 = '0, w1_base = '0, w1;
  logic        req, wr, ack, err;
  logic [15:0] addr, wdata, rdata;
  logic        busy, ok, fail;
  logic [31:0] last0, last1;

  // bench-side stimulus knobs
  logic [15:0] init_val = '0, rxv = '0;
  int          err_idx = 0, up_after = 0, lat = 0;

  // model state
  int          cyc = 0, txn = 0, rdv_cnt = 0, wr_cnt = 0, wcnt = 0;
  int          last_ack = 0, set_cyc = 0;
  logic        have_prev = 1'b0, ov_on = 1'b0, req_d = 1'b0;
  logic [15:0] ovr_reg = '0;
  int          mchk = 0, mfail = 0;

  int          checks = 0, fails = 0;

  assign w1 = (up_after != 0 && rdv_cnt >= up_after) ? 32'h0000_0010 : w1_base;

  link_train_mon #(
    .MAX_ATTEMPTS (MAXA),
    .HOLD_CYC     (HOLD),
    .GAP_CYC      (GAP)
  ) u0 (
    .clk_i             (clk),
    .rst_ni            (rst_n),
    .start_i           (start),
    .state_word_i      (w0),
    .link_word_i       (w1),
    .phy_req_o         (req),
    .phy_wr_o          (wr),
    .phy_addr_o        (addr),
    .phy_wdata_o       (wdata),
    .phy_ack_i         (ack),
    .phy_err_i         (err),
    .phy_rdata_i       (rdata),
    .busy_o            (busy),
    .link_ok_o         (ok),
    .link_fail_o       (fail),
    .last_state_word_o (last0),
    .last_link_word_o  (last1)
  );

  always @(posedge clk) cyc <= cyc + 1;

  // PHY register port model with latency, error injection and timing checks
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack <= 1'b0; err <= 1'b0; rdata <= '0; wcnt <= 0; req_d <= 1'b0;
    end else begin
      req_d <= req;
      if (start && !busy) begin
        rdv_cnt <= 0; wr_cnt <= 0; txn <= 0; ovr_reg <= init_val;
        ov_on <= 1'b0; have_prev <= 1'b0;
      end
      if (req && !req_d) begin
        if (addr == RXS && have_prev) begin
          mchk <= mchk + 1;
          if (cyc - last_ack < GAP) begin
            mfail <= mfail + 1;
            $display("FAIL R7 attempt gap: act=%0d exp>=%0d", cyc - last_ack, GAP);
          end
        end
        if (addr == OVR && !wr && ov_on) begin
          mchk <= mchk + 1;
          if (cyc - set_cyc < HOLD) begin
            mfail <= mfail + 1;
            $display("FAIL R4 hold time: act=%0d exp>=%0d", cyc - set_cyc, HOLD);
          end
        end
      end
      if (ack) begin
        ack <= 1'b0; err <= 1'b0;
      end else if (req) begin
        if (wcnt >= lat) begin
          wcnt <= 0;
          ack <= 1'b1;
          txn <= txn + 1;
          err <= (txn + 1 == err_idx);
          last_ack <= cyc;
          have_prev <= 1'b1;
          if (addr == RXS) begin
            rdv_cnt <= rdv_cnt + 1;
            rdata <= rxv;
          end else if (addr == OVR && !wr) begin
            rdata <= ovr_reg;
          end else if (addr == OVR && wr) begin
            if (txn + 1 != err_idx) begin
              mchk <= mchk + 1;
              wr_cnt <= wr_cnt + 1;
              ovr_reg <= wdata;
              if (wdata == (ovr_reg | MASK)) begin
                ov_on <= 1'b1; set_cyc <= cyc;
              end else if (ov_on && wdata == (ovr_reg & ~MASK)) begin
                ov_on <= 1'b0;
              end else begin
                mfail <= mfail + 1;
                $display("FAIL R4 write value: act=%h exp=%h or %h", wdata,
                         ovr_reg | MASK, ovr_reg & ~MASK);
              end
            end
          end else begin
            rdata <= 16'hDEAD;
            mchk <= mchk + 1; mfail <= mfail + 1;
            $display("FAIL R3 unexpected address: act=%h exp=%h/%h", addr, RXS, OVR);
          end
        end else begin
          wcnt <= wcnt + 1;
        end
      end
    end
  end

  task automatic chk(input bit cond, input string rq, input longint act, input longint exp);
    checks++;
    if (!cond) begin
      fails++;
      $display("FAIL %s: act=%0h exp=%0h", rq, act, exp);
    end
  endtask

  task automatic run(input logic [15:0] ini, input logic [15:0] rx, input logic [31:0] s0,
                     input logic [31:0] s1, input int eix, input int upk, input int lt,
                     input bit mid, input int exp_att, input int exp_wr, input bit exp_ok,
                     input logic [15:0] exp_fin);
    @(negedge clk);
    init_val = ini; rxv = rx; w0 = s0; w1_base = s1; err_idx = eix; up_after = upk; lat = lt;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy && !ok && !fail, "R9 start clears result", {busy, ok, fail}, 3'b100);
    if (mid) begin
      repeat (20) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (busy) @(negedge clk);
    chk(ok == exp_ok, "R2 link_ok", ok, exp_ok);
    chk(fail == !exp_ok, "R8 link_fail", fail, !exp_ok);
    chk(rdv_cnt == exp_att, "R3 attempt count", rdv_cnt, exp_att);
    chk(wr_cnt == exp_wr, "R4 override writes", wr_cnt, exp_wr);
    chk(ovr_reg == exp_fin, "R4 final override reg", ovr_reg, exp_fin);
    chk(!req, "R5 no access after run", req, 0);
    if (!exp_ok) begin
      chk(last0 == s0, "R8 last state word", last0, s0);
      chk(last1 == s1, "R8 last link word", last1, s1);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: act=timeout exp=done");
    $display("  [TB] %0d tests run, %0d failed", checks + mchk + 1, fails + mfail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!busy && !ok && !fail && !req, "R1 reset outputs", {busy, ok, fail, req}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !ok && !fail && !req, "R1 after reset release", {busy, ok, fail, req}, 0);

    // R2: up/training table, only up=1 training=0 is established
    for (int k = 0; k < 4; k++) begin
      logic [31:0] lw;
      bit up;
      lw = 32'h0A5F_03C0 ^ 32'(k * 32'h0101_0000);
      lw[4] = k[0]; lw[29] = k[1];
      up = k[0] && !k[1];
      run(16'h0F0F, 16'h0001, 32'h0, lw, 0, 0, k % 3, 1'b0,
          up ? 0 : MAXA, 0, up, 16'h0F0F);
    end

    // R3 sweep over link state and receive-valid, with ignored bits varied
    for (int s = 0; s < 64; s++) begin
      for (int r = 0; r < 2; r++) begin
        logic [31:0] sw, lw;
        logic [15:0] ini, rx;
        bit stk;
        int wn;
        sw = {26'(32'h2AA_AAAA ^ (s * 977)), 6'(s)};
        rx = {15'(16'h5A5A ^ (s * 31)), 1'(r)};
        case (s % 4)
          0: lw = 32'h2000_0010;
          1: lw = 32'h0000_0000;
          2: lw = 32'hDFFF_FFEF;
          default: lw = 32'hFFFF_FFFF;
        endcase
        ini = 16'(16'h1234 ^ (s * 16'h0347) ^ (r * 16'h0028));
        stk = (s == 13) && (r == 0);
        wn  = stk ? 2 * MAXA : 0;
        run(ini, rx, sw, lw, 0, 0, (s + r) % 3, 1'b0, MAXA, wn, 1'b0,
            (wn > 0) ? (ini & ~MASK) : ini);
      end
    end

    // R6: errors at chosen points in a stuck attempt
    run(16'hFFFF, 16'h0000, 32'h0000_000D, 32'h0, 2, 0, 1, 1'b0,
        MAXA, 2 * (MAXA - 1), 1'b0, 16'hFFD7);              // set-read fails
    run(16'h0000, 16'h0000, 32'h0000_004D, 32'h0, 4, 0, 0, 1'b0,
        MAXA, 2 * (MAXA - 1) + 1, 1'b0, 16'h0000);          // clear-read fails
    run(16'h8001, 16'h0000, 32'h0000_000D, 32'h0, 5, 0, 2, 1'b0,
        MAXA, 2 * (MAXA - 1) + 1, 1'b0, 16'h8001);          // clear-write fails
    run(16'h00FF, 16'h0000, 32'h0000_000D, 32'h0, 1, 0, 0, 1'b0,
        MAXA, 2 * (MAXA - 1), 1'b0, 16'h00D7);              // status read fails
    run(16'h3333, 16'h0001, 32'h0000_000C, 32'h0, 3, 0, 1, 1'b0,
        MAXA, 0, 1'b0, 16'h3333);                           // error while not stuck

    // R2/R4: link comes up after two repaired attempts
    run(16'h1111, 16'h0000, 32'h0000_000D, 32'h0, 0, 2, 1, 1'b0,
        2, 4, 1'b1, 16'h1111 & ~MASK);

    // R9: start while busy is ignored
    run(16'h4444, 16'h0000, 32'h0000_000D, 32'h2000_0010, 0, 0, 0, 1'b1,
        MAXA, 2 * MAXA, 1'b0, 16'h4444 & ~MASK);

    // R9: restart after failure reaches success
    run(16'h5555, 16'h0001, 32'h0000_000D, 32'h0000_0010, 0, 0, 0, 1'b0,
        0, 0, 1'b1, 16'h5555);

    repeat (5) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", checks + mchk, fails + mfail);
    $finish;
  end

endmodule